// File: doc/BRIEF.md
# DTMF Steering Guard-Time Validator

This block replaces the resistor-capacitor steering network that normally sits beside a tone-pair receiver. The tone detector raises an early-steering level while it sees a valid pair of frequencies and presents the decoded 4-bit digit. The validator only accepts a digit after that level has stayed high for a programmable number of timebase ticks, and only accepts the following pause after the level has stayed low for a separate programmable number of ticks.

When a digit is accepted, its code goes into a receive register and a guard-time output is asserted. A few clock cycles later, once the register has settled, a delayed-steering level rises and a single-cycle new-digit pulse is issued for the status logic. Short bursts are rejected. Short dropouts inside an accepted tone are ignored. A receiver-disable input holds the block idle. The timebase is an external tick, typically one per millisecond. With that tick, thresholds of 40 and 40 give a minimum accepted tone and a minimum pause of 40 ms. Bursts and dropouts of 20 ms are then rejected.

Top module: `dtmf_steer_guard`

## Requirements
- R1: A digit is registered only on the tick at which `est_i` has been high on `present_lim_i` consecutive ticks while idle. A low `est_i` in any cycle restarts the count. A shorter burst leaves `rx_data_o`, `dstb_o` and `new_digit_o` unchanged.
- R2: On registration, `rx_data_o` takes the value of `digit_i` in that cycle and `gt_o` goes high. While a digit is registered, `gt_o` repeats `est_i` one cycle late. In the idle state `gt_o` is low.
- R3: `dstb_o` rises exactly `SETTLE_CYC` clock cycles after the edge that latches the digit. In that same cycle `new_digit_o` is high for exactly one cycle.
- R4: While `dstb_o` is high, `est_i` low on `absent_lim_i` consecutive ticks accepts the pause. `dstb_o` falls on that tick, and a later burst can register a new digit.
- R5: A dropout lasting fewer than `absent_lim_i` ticks leaves `dstb_o` high and `rx_data_o` unchanged, and it produces no `new_digit_o` pulse, even if `est_i` returns with a different `digit_i`.
- R6: While `rx_off_i` is high, the block returns to idle on the next edge, with `gt_o`, `dstb_o` and `new_digit_o` low. It registers nothing, and `rx_data_o` keeps its value.
- R7: `rx_data_o` holds the last registered digit until the next registration.
- R8: After reset, `rx_data_o` is 0 and `gt_o`, `dstb_o` and `new_digit_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_off_i | input | 1 | Receiver disable; high holds the block idle |
| tick_i | input | 1 | Guard timebase enable, one cycle per tick |
| est_i | input | 1 | Early steering: high while a valid tone pair is seen |
| digit_i | input | DW | Decoded digit from the tone detector |
| present_lim_i | input | CW | Tone-present guard, in ticks |
| absent_lim_i | input | CW | Tone-absent guard, in ticks |
| rx_data_o | output | DW | Receive register |
| gt_o | output | 1 | Guard-time output |
| dstb_o | output | 1 | Delayed steering: high while a registered signal is valid |
| new_digit_o | output | 1 | One-cycle pulse when `dstb_o` rises |

## Verification
The assertions check the following properties on every cycle:
- the receive register changes only after a tick with `est_i` high;
- the register is stable while delayed steering is held;
- `gt_o` never leads `est_i`;
- the new-digit pulse coincides with a rising `dstb_o`;
- `dstb_o` falls only after `est_i` was low or the receiver was disabled;
- disabling the receiver silences all outputs.

Some behaviour only the bench scenarios can show:
- the exact accept and reject boundaries, by sweeping burst length against the present guard and dropout length against the absent guard;
- the settle latency in cycles;
- a digit substituted during a tolerated dropout leaves no trace.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HELD   = 2'd2
  } steer_state_e;
endpackage

// File: rtl/steer_guard_timer.sv
// Consecutive-tick counter; done on the tick that reaches the limit.
module steer_guard_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);
  localparam int XW = CW + 1;

  logic [CW-1:0] cnt_q;
  logic [XW-1:0] next_cnt;

  assign next_cnt = {1'b0, cnt_q} + XW'(1);
  assign done_o   = run_i && tick_i && (next_cnt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i)               cnt_q <= '0;
    else if (tick_i && !done_o)    cnt_q <= next_cnt[CW-1:0];
  end

  // R1: an interrupted run always restarts from zero
  a_r1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/steer_settle_timer.sv
// Counts clock cycles of the settle window after a latch.
module steer_settle_timer #(
  parameter int SETTLE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int SW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == SW'(SETTLE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + SW'(1);
  end

  a_r3_settle_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SW'(SETTLE_CYC - 1));
endmodule

// File: rtl/dtmf_steer_guard.sv
module dtmf_steer_guard
  import dtmf_steer_pkg::*;
#(
  parameter int DW         = 4,
  parameter int CW         = 8,
  parameter int SETTLE_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_off_i,
  input  logic          tick_i,
  input  logic          est_i,
  input  logic [DW-1:0] digit_i,
  input  logic [CW-1:0] present_lim_i,
  input  logic [CW-1:0] absent_lim_i,
  output logic [DW-1:0] rx_data_o,
  output logic          gt_o,
  output logic          dstb_o,
  output logic          new_digit_o
);
  steer_state_e state_q;
  logic p_run, a_run, s_run;
  logic p_done, a_done, s_done;

  assign p_run = !rx_off_i && (state_q == ST_IDLE) && est_i;
  assign a_run = !rx_off_i && (state_q == ST_HELD) && !est_i;
  assign s_run = !rx_off_i && (state_q == ST_SETTLE);

  steer_guard_timer #(.CW(CW)) u_present (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(p_run), .tick_i(tick_i),
    .limit_i(present_lim_i), .done_o(p_done));

  steer_guard_timer #(.CW(CW)) u_absent (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(a_run), .tick_i(tick_i),
    .limit_i(absent_lim_i), .done_o(a_done));

  steer_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(s_run), .done_o(s_done));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rx_data_o   <= '0;
      gt_o        <= 1'b0;
      dstb_o      <= 1'b0;
      new_digit_o <= 1'b0;
    end else begin
      new_digit_o <= 1'b0;
      if (rx_off_i) begin
        state_q <= ST_IDLE;
        gt_o    <= 1'b0;
        dstb_o  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            gt_o <= 1'b0;
            if (p_done) begin
              rx_data_o <= digit_i;
              gt_o      <= 1'b1;
              state_q   <= ST_SETTLE;
            end
          end
          ST_SETTLE: begin
            gt_o <= est_i;
            if (s_done) begin
              dstb_o      <= 1'b1;
              new_digit_o <= 1'b1;
              state_q     <= ST_HELD;
            end
          end
          ST_HELD: begin
            gt_o <= est_i;
            if (a_done) begin
              dstb_o  <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: register only moves after a tick with steering high
  a_r1_latch_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> $past(est_i) && $past(tick_i) && !$past(rx_off_i));
  // R2: guard output never leads steering input
  a_r2_gt_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gt_o |-> $past(est_i));
  // R3: pulse marks a rising delayed steering
  a_r3_pulse_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_digit_o |-> dstb_o && !$past(dstb_o));
  // R4: pause accepted only with steering low, or by disable
  a_r4_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dstb_o) |-> !$past(est_i) || $past(rx_off_i));
  // R6: disable silences outputs
  a_r6_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_off_i |=> !gt_o && !dstb_o && !new_digit_o);
  // R7: data held while a signal is valid
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dstb_o && $past(dstb_o) |-> $stable(rx_data_o));
endmodule

// File: tb/sim_dtmf_steer_guard.sv
module sim_dtmf_steer_guard;
  localparam int DW = 4, CW = 8, SET = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_off = 1'b0, tick = 1'b0, est = 1'b0;
  logic [DW-1:0] digit = '0;
  logic [CW-1:0] plim = 8'd2, alim = 8'd2;
  logic [DW-1:0] rx_data;
  logic gt, dstb, nd;

  int total = 0, bad = 0, npulse = 0;
  logic [DW-1:0] exp_data = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  dtmf_steer_guard #(.DW(DW), .CW(CW), .SETTLE_CYC(SET)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_off_i(rx_off), .tick_i(tick),
    .est_i(est), .digit_i(digit), .present_lim_i(plim), .absent_lim_i(alim),
    .rx_data_o(rx_data), .gt_o(gt), .dstb_o(dstb), .new_digit_o(nd));

  always @(negedge clk) if (nd) npulse++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic off, input logic e, input logic t);
    @(negedge clk);
    rx_off = off; est = e; tick = t;
    @(posedge clk);
    #2;
  endtask

  task automatic go_idle();
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R8 reset state
    chk("R8 data", int'(rx_data), 0);
    chk("R8 gt/dstb/nd", int'({gt, dstb, nd}), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1/R7 sweep: burst length vs present guard
    for (int p = 1; p <= 4; p++) begin
      for (int l = 0; l <= 5; l++) begin
        int base;
        bit reg_ok;
        logic [DW-1:0] d;
        go_idle();
        plim = CW'(p); alim = 8'd3;
        d = DW'((p * 6 + l) % 16);
        digit = d;
        base = npulse;
        for (int k = 0; k < l; k++) cyc(1'b0, 1'b1, 1'b1);
        for (int k = 0; k < SET + 2; k++) cyc(1'b0, 1'b0, 1'b0);
        reg_ok = (l >= p);
        if (reg_ok) exp_data = d;
        chk("R1 pulses", npulse - base, int'(reg_ok));
        chk("R1 dstb", int'(dstb), int'(reg_ok));
        chk("R7 data", int'(rx_data), int'(exp_data));
        chk("R2 gt low after est low", int'(gt), 0);
      end
    end

    // R3 exact settle latency, R2 gt on latch
    go_idle();
    plim = 8'd1; digit = 4'hB;
    cyc(1'b0, 1'b1, 1'b1);
    chk("R2 latch data", int'(rx_data), 11);
    chk("R2 gt at latch", int'(gt), 1);
    chk("R3 dstb edge1", int'(dstb), 0);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R3 dstb edge2", int'(dstb), 0);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R3 dstb edge3", int'(dstb), 1);
    chk("R3 pulse edge3", int'(nd), 1);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R3 pulse one cycle", int'(nd), 0);
    chk("R3 dstb held", int'(dstb), 1);
    exp_data = 4'hB;

    // R4/R5 sweep: dropout length vs absent guard
    for (int a = 2; a <= 4; a++) begin
      for (int dr = 1; dr <= 5; dr++) begin
        int base;
        logic [DW-1:0] da, db;
        go_idle();
        plim = 8'd2; alim = CW'(a);
        da = DW'((dr * 3 + a) % 16); db = ~da;
        digit = da;
        base = npulse;
        cyc(1'b0, 1'b1, 1'b1); cyc(1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b0);
        chk("R2 gt follows est", int'(gt), 1);
        digit = db;
        for (int k = 0; k < dr; k++) cyc(1'b0, 1'b0, 1'b1);
        chk("R4/R5 dstb after dropout", int'(dstb), int'(dr < a));
        chk("R2 gt low in dropout", int'(gt), 0);
        cyc(1'b0, 1'b1, 1'b1); cyc(1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b0);
        if (dr >= a) begin
          chk("R4 new digit after pause", int'(rx_data), int'(db));
          chk("R4 pulses", npulse - base, 2);
        end else begin
          chk("R5 data kept", int'(rx_data), int'(da));
          chk("R5 no retrigger", npulse - base, 1);
        end
        exp_data = rx_data;
      end
    end

    // R6 disable: nothing registers, data kept
    begin
      int base;
      go_idle();
      plim = 8'd1; digit = ~exp_data;
      base = npulse;
      for (int k = 0; k < 6; k++) cyc(1'b1, 1'b1, 1'b1);
      chk("R6 no pulse", npulse - base, 0);
      chk("R6 outputs low", int'({gt, dstb}), 0);
      chk("R6 data kept", int'(rx_data), int'(exp_data));
      digit = 4'h5;
      cyc(1'b0, 1'b1, 1'b1);
      for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b0);
      chk("R6 registered before disable", int'(dstb), 1);
      cyc(1'b1, 1'b1, 1'b0);
      chk("R6 disable drops outputs", int'({gt, dstb, nd}), 0);
      chk("R6 data retained", int'(rx_data), 5);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule